// File: doc/BRIEF.md
# Register-Driven SPI Word Master

This block is the serial engine of an SPI master that software drives through six 32-bit registers. A mode register fixes the clock idle level, the clock phase, the bit order, the word length and an internal loopback path, and it holds the master and enable bits. A write to the transmit register queues one word. The engine then moves that word into its shifter and runs one full-duplex exchange. The word clocked in from the far side lands right-aligned in the receive register.

Two event flags report progress: one says a received word is waiting, the other says the transmit register can take a new word. A mask register picks which flags drive the single interrupt line. Writing a 1 to an event bit clears it. Chip selects are driven outside the block, and so is the bit-rate prescaler. The prescaler supplies a one-cycle `halfTick` pulse at twice the serial bit rate. Each pulse that arrives during an exchange moves the serial clock by one edge.

Top module: `spi_word_master`

## Requirements
- R1: After reset, every register reads zero (word indexes: 0 mode, 1 event, 2 mask, 3 command, 4 transmit, 5 receive), the serial clock is low, and the interrupt is low.
- R2: While no exchange runs, the serial clock rests at the level in mode bit 29 (1 means high). An exchange of N bits toggles the serial clock exactly 2N times, once per `halfTick`, and leaves it at that rest level.
- R3: With mode bit 28 clear, the input is sampled on each leading clock edge and the output changes on trailing edges. With bit 28 set, the output changes on leading edges and the input is sampled on trailing edges. A leading edge is the edge that leaves the rest level.
- R4: Mode bit 26 set shifts the most significant bit first. With bit 26 clear the least significant bit goes first. The receive register is right-aligned either way.
- R5: Mode bits 23:20 hold the word length minus one for lengths 4 to 16. The value 0 selects 32 bits. The values 1 and 2 act as 4 bits. Transmit bits above the word length are not sent, and receive bits above it read zero.
- R6: Mode bit 30 loops the serial output back to the serial input, and the external input has no effect.
- R7: An exchange runs only while the enable bit (mode bit 24) and the master bit (mode bit 25) are both set. Otherwise the shifter stays idle, the clock does not toggle, and a queued word waits.
- R8: Event bit 8 (transmit not full) clears on the clock edge that writes the transmit register. It sets on the next edge at which the queued word enters the shifter.
- R9: Event bit 9 (receive not empty) sets when the last bit of a word is sampled. A word that completes while it is still set overwrites the receive register.
- R10: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged.
- R11: The interrupt output is high exactly when some event bit is set and its mask bit (same bit position, 9 or 8) is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register word index |
| busWr | input | 1 | Register write strobe |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data for `busAddr` (combinational) |
| halfTick | input | 1 | Half-bit-period pulse from the external prescaler |
| sclkOut | output | 1 | Serial clock |
| mosiOut | output | 1 | Serial data out |
| misoIn | input | 1 | Serial data in |
| irqOut | output | 1 | Masked event interrupt |

## Verification
The hardest case to reach from the ports is the trade of timing between the two phase settings. The design must sample the far side at the right half-period, and it must not change its own output on the edge where the far side samples. The bench drives `misoIn` from a slave model that watches `sclkOut`. That model changes its bit only on the edges R3 allows and captures `mosiOut` only on the opposite edges, so a phase error corrupts both received words. Each exchange uses a different clock level, phase, order and length, and the 32-bit and aliased 4-bit encodings are included. Two further cases use loopback with the external input held high: one checks that a queued word waits while the unit is disabled, the other that a second word overwrites an unread first word.

// File: rtl/spiwm_pkg.sv
package spiwm_pkg;
  localparam int DATA_W    = 32;
  localparam int LEN_W     = $clog2(DATA_W) + 1;
  localparam int BIT_IDX_W = $clog2(DATA_W);
  localparam int EDGE_W    = LEN_W + 1;
  localparam int LEN_FLD_W = 4;

  // mode bit positions (software-visible)
  localparam int M_LOOP   = 30;
  localparam int M_CPOL   = 29;
  localparam int M_CPHA   = 28;
  localparam int M_MSB    = 26;
  localparam int M_MASTER = 25;
  localparam int M_EN     = 24;
  localparam int M_LEN_LO = 20;

  // event / mask bit positions
  localparam int EV_RNE = 9;
  localparam int EV_TNF = 8;

  // register word indexes
  localparam int R_MODE  = 0;
  localparam int R_EVENT = 1;
  localparam int R_MASK  = 2;
  localparam int R_CMD   = 3;
  localparam int R_TX    = 4;
  localparam int R_RX    = 5;

  typedef struct packed {
    logic load;
    logic shiftOut;
    logic sampleIn;
    logic capture;
  } spiwmStrobe_t;

  function automatic logic [LEN_W-1:0] decodeLen(input logic [LEN_FLD_W-1:0] fld);
    if (fld == '0)
      return LEN_W'(DATA_W);
    else if (fld < LEN_FLD_W'(3))
      return LEN_W'(4);
    else
      return LEN_W'(fld) + LEN_W'(1);
  endfunction
endpackage

// File: rtl/spiwm_dp.sv
module spiwm_dp
  import spiwm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  spiwmStrobe_t        stb,
  input  logic [DATA_W-1:0]   txWord,
  input  logic                lsbFirst,
  input  logic [LEN_W-1:0]    wordLen,
  input  logic                loopEn,
  input  logic                misoIn,
  output logic                mosiOut,
  output logic [DATA_W-1:0]   rxWord
);
  logic [DATA_W-1:0]    txSh;
  logic [DATA_W-1:0]    rxSh;
  logic [DATA_W-1:0]    rxNext;
  logic [BIT_IDX_W-1:0] topIdx;
  logic                 inBit;

  // highest bit of the active word
  assign topIdx  = BIT_IDX_W'(wordLen - LEN_W'(1));
  assign mosiOut = lsbFirst ? txSh[0] : txSh[topIdx];
  assign inBit   = loopEn ? mosiOut : misoIn;

  // LSB-first inserts at the word's top bit so the result ends right-aligned
  always_comb begin
    if (lsbFirst)
      rxNext = (rxSh >> 1) | (DATA_W'(inBit) << topIdx);
    else
      rxNext = {rxSh[DATA_W-2:0], inBit};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh <= '0;
    end else if (stb.load) begin
      txSh <= txWord;
    end else if (stb.shiftOut) begin
      txSh <= lsbFirst ? (txSh >> 1) : (txSh << 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSh <= '0;
    end else if (stb.load) begin
      rxSh <= '0;
    end else if (stb.sampleIn) begin
      rxSh <= rxNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rxWord <= '0;
    else if (stb.capture)
      rxWord <= rxNext;
  end
endmodule

// File: rtl/spiwm_ctrl.sv
module spiwm_ctrl
  import spiwm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic                halfTick,
  input  logic [DATA_W-1:0]   rxWord,
  output spiwmStrobe_t        stb,
  output logic [DATA_W-1:0]   txWord,
  output logic                lsbFirst,
  output logic [LEN_W-1:0]    wordLen,
  output logic                loopEn,
  output logic                sclkOut,
  output logic                irqOut,
  output logic                busyOut,
  output logic [DATA_W-1:0]   modeOut,
  output logic [DATA_W-1:0]   eventOut,
  output logic [DATA_W-1:0]   maskOut
);
  logic [DATA_W-1:0] modeQ, cmdQ, txHold;
  logic              rneQ, tnfQ, maskRne, maskTnf;
  logic              txFull, busy, sclkQ;
  logic [EDGE_W-1:0] edgeCnt, twoN;
  logic              cpol, cpha, runOk, tick, lead, lastEdge, preLast;
  logic              modeWr, evWr, maskWr, cmdWr, txWr;

  assign modeWr = busWr && (busAddr == ADDR_W'(R_MODE));
  assign evWr   = busWr && (busAddr == ADDR_W'(R_EVENT));
  assign maskWr = busWr && (busAddr == ADDR_W'(R_MASK));
  assign cmdWr  = busWr && (busAddr == ADDR_W'(R_CMD));
  assign txWr   = busWr && (busAddr == ADDR_W'(R_TX));

  assign cpol     = modeQ[M_CPOL];
  assign cpha     = modeQ[M_CPHA];
  assign loopEn   = modeQ[M_LOOP];
  assign lsbFirst = !modeQ[M_MSB];
  assign runOk    = modeQ[M_EN] && modeQ[M_MASTER];
  assign wordLen  = decodeLen(modeQ[M_LEN_LO +: LEN_FLD_W]);
  assign twoN     = {wordLen, 1'b0};
  assign lastEdge = (edgeCnt == twoN - EDGE_W'(1));
  assign preLast  = (edgeCnt == twoN - EDGE_W'(2));

  // strobes to the datapath
  assign tick = busy && runOk && halfTick;
  assign lead = !edgeCnt[0];
  assign stb.load     = runOk && !busy && txFull;
  assign stb.sampleIn = tick && (cpha ? !lead : lead);
  assign stb.shiftOut = tick && (cpha ? (lead && (edgeCnt != '0)) : !lead);
  assign stb.capture  = stb.sampleIn && (cpha ? lastEdge : preLast);

  // plain storage registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= '0;
      cmdQ    <= '0;
      maskRne <= 1'b0;
      maskTnf <= 1'b0;
      txHold  <= '0;
    end else begin
      if (modeWr) modeQ <= busWdata;
      if (cmdWr)  cmdQ  <= busWdata;
      if (maskWr) begin
        maskRne <= busWdata[EV_RNE];
        maskTnf <= busWdata[EV_TNF];
      end
      if (txWr) txHold <= busWdata;
    end
  end

  // transmit holding state
  always_ff @(posedge clk) begin
    if (!rstN)
      txFull <= 1'b0;
    else if (txWr)
      txFull <= 1'b1;
    else if (stb.load)
      txFull <= 1'b0;
  end

  // exchange sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      edgeCnt <= '0;
    end else if (stb.load) begin
      busy    <= 1'b1;
      edgeCnt <= '0;
    end else if (busy && !runOk) begin
      busy <= 1'b0;
    end else if (tick) begin
      edgeCnt <= edgeCnt + EDGE_W'(1);
      if (lastEdge) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      sclkQ <= 1'b0;
    else if (tick)
      sclkQ <= !sclkQ;
    else if (!busy || !runOk)
      sclkQ <= cpol;
  end

  // event flags, set beats clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rneQ <= 1'b0;
      tnfQ <= 1'b0;
    end else begin
      if (stb.capture)
        rneQ <= 1'b1;
      else if (evWr && busWdata[EV_RNE])
        rneQ <= 1'b0;

      if (txWr)
        tnfQ <= 1'b0;
      else if (stb.load)
        tnfQ <= 1'b1;
      else if (evWr && busWdata[EV_TNF])
        tnfQ <= 1'b0;
    end
  end

  always_comb begin
    eventOut = '0;
    eventOut[EV_RNE] = rneQ;
    eventOut[EV_TNF] = tnfQ;
    maskOut = '0;
    maskOut[EV_RNE] = maskRne;
    maskOut[EV_TNF] = maskTnf;
  end

  always_comb begin
    case (busAddr)
      ADDR_W'(R_MODE):  busRdata = modeQ;
      ADDR_W'(R_EVENT): busRdata = eventOut;
      ADDR_W'(R_MASK):  busRdata = maskOut;
      ADDR_W'(R_CMD):   busRdata = cmdQ;
      ADDR_W'(R_TX):    busRdata = txHold;
      ADDR_W'(R_RX):    busRdata = rxWord;
      default:          busRdata = '0;
    endcase
  end

  assign irqOut  = (rneQ && maskRne) || (tnfQ && maskTnf);
  assign sclkOut = sclkQ;
  assign txWord  = txHold;
  assign busyOut = busy;
  assign modeOut = modeQ;
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spiwm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic                halfTick,
  output logic                sclkOut,
  output logic                mosiOut,
  input  logic                misoIn,
  output logic                irqOut
);
  spiwmStrobe_t      stb;
  logic [DATA_W-1:0] txWord, rxWord, modeQ, eventQ, maskQ;
  logic              lsbFirst, loopEn, busy;
  logic [LEN_W-1:0]  wordLen;

  spiwm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata),
    .halfTick(halfTick), .rxWord(rxWord),
    .stb(stb), .txWord(txWord), .lsbFirst(lsbFirst), .wordLen(wordLen),
    .loopEn(loopEn), .sclkOut(sclkOut), .irqOut(irqOut), .busyOut(busy),
    .modeOut(modeQ), .eventOut(eventQ), .maskOut(maskQ)
  );

  spiwm_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txWord(txWord),
    .lsbFirst(lsbFirst), .wordLen(wordLen), .loopEn(loopEn),
    .misoIn(misoIn), .mosiOut(mosiOut), .rxWord(rxWord)
  );
endmodule

// File: rtl/spiwm_chk.sv
module spiwm_chk
  import spiwm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWr,
  input logic [DATA_W-1:0]   busWdata,
  input logic                sclkOut,
  input logic                busy,
  input spiwmStrobe_t        stb,
  input logic [DATA_W-1:0]   modeQ,
  input logic [DATA_W-1:0]   eventQ
);
  logic txWr, evWr;
  assign txWr = busWr && (busAddr == ADDR_W'(R_TX));
  assign evWr = busWr && (busAddr == ADDR_W'(R_EVENT));

  assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $stable(modeQ)) |-> (sclkOut == modeQ[M_CPOL]));

  assert_halt_when_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !modeQ[M_EN] |=> !busy);

  assert_tnf_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    txWr |=> !eventQ[EV_TNF]);

  assert_tnf_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && !txWr) |=> eventQ[EV_TNF]);

  assert_rne_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> eventQ[EV_RNE]);

  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rstN)
    (evWr && busWdata[EV_RNE] && !stb.capture) |=> !eventQ[EV_RNE]);
endmodule

bind spi_word_master spiwm_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
  .busWdata(busWdata), .sclkOut(sclkOut), .busy(busy), .stb(stb),
  .modeQ(modeQ), .eventQ(eventQ)
);

// File: tb/tb_spi_word_master.sv
module tb_spi_word_master;
  localparam logic [2:0] A_MODE = 3'd0, A_EVENT = 3'd1, A_MASK = 3'd2,
                         A_CMD = 3'd3, A_TX = 3'd4, A_RX = 3'd5;
  localparam int WAIT_CYC = 200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        halfTick = 1'b0;
  logic        sclkOut, mosiOut, irqOut;
  logic        misoIn = 1'b0;

  int checks = 0;
  int failures = 0;

  // slave model state
  bit          armed = 1'b0;
  bit          sCpol, sCpha, sMsb;
  int          sLen, sIdx, edgeSeen, toggleCnt;
  logic [31:0] sWord, slaveRx;

  spi_word_master dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .halfTick(halfTick),
    .sclkOut(sclkOut), .mosiOut(mosiOut), .misoIn(misoIn), .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      halfTick = ~halfTick;
    end
  end

  function automatic logic slaveBit(int idx);
    if (idx >= sLen) return 1'b0;
    return sMsb ? sWord[sLen-1-idx] : sWord[idx];
  endfunction

  always @(sclkOut) toggleCnt++;

  always @(sclkOut) begin
    #1;
    if (armed) begin
      edgeSeen++;
      if (sclkOut != sCpol) begin
        if (!sCpha) begin
          if (sIdx < sLen) slaveRx[sMsb ? sLen-1-sIdx : sIdx] = mosiOut;
        end else begin
          misoIn = slaveBit(sIdx);
        end
      end else begin
        if (!sCpha) begin
          sIdx++;
          misoIn = slaveBit(sIdx);
        end else begin
          if (sIdx < sLen) slaveRx[sMsb ? sLen-1-sIdx : sIdx] = mosiOut;
          sIdx++;
        end
      end
    end
  end

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic regWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic regRead(logic [2:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  function automatic logic [31:0] modeWord(bit loop, bit cpol, bit cpha, bit msb,
                                           logic [3:0] fld, bit en);
    return (32'(loop) << 30) | (32'(cpol) << 29) | (32'(cpha) << 28) |
           (32'(msb) << 26) | (32'h1 << 25) | (32'(en) << 24) | (32'(fld) << 20);
  endfunction

  function automatic logic [31:0] lenMask(int n);
    return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic testReset();
    logic [31:0] r;
    for (int i = 0; i < 6; i++) begin
      regRead(3'(i), r);
      check("R1", $sformatf("reg %0d after reset", i), r, 32'h0);
    end
    check("R1", "sclk after reset", 32'(sclkOut), 32'h0);
    check("R1", "irq after reset", 32'(irqOut), 32'h0);
  endtask

  task automatic xfer(string req, bit cpol, bit cpha, bit msb, logic [3:0] fld,
                      int n, logic [31:0] txw, logic [31:0] sw);
    logic [31:0] r;
    regWrite(A_EVENT, 32'h300);
    sCpol = cpol; sCpha = cpha; sMsb = msb; sLen = n; sWord = sw;
    regWrite(A_MODE, modeWord(1'b0, cpol, cpha, msb, fld, 1'b1));
    repeat (2) @(negedge clk);
    check(req, "idle clock level", 32'(sclkOut), 32'(cpol));
    sIdx = 0; slaveRx = '0; edgeSeen = 0;
    misoIn = cpha ? 1'b0 : slaveBit(0);
    armed = 1'b1;
    regWrite(A_TX, txw);
    repeat (WAIT_CYC) @(negedge clk);
    armed = 1'b0;
    regRead(A_RX, r);
    check(req, "received word", r, sw & lenMask(n));
    check(req, "word seen by slave", slaveRx, txw & lenMask(n));
    check(req, "clock edge count", 32'(edgeSeen), 32'(2 * n));
    check(req, "clock back at idle", 32'(sclkOut), 32'(cpol));
    regRead(A_EVENT, r);
    check(req, "events after exchange", r, 32'h300);
  endtask

  task automatic testTnfAndIrq();
    logic [31:0] r;
    regWrite(A_MODE, modeWord(1'b1, 1'b0, 1'b0, 1'b1, 4'd7, 1'b1));
    regWrite(A_EVENT, 32'h300);
    regRead(A_EVENT, r);
    check("R10", "W1C clears both flags", r, 32'h0);
    regWrite(A_MASK, 32'h200);
    regRead(A_MASK, r);
    check("R11", "mask readback", r, 32'h200);
    regWrite(A_TX, 32'h0000_00C3);
    regRead(A_EVENT, r);
    check("R8", "tnf low right after write", r & 32'h100, 32'h0);
    @(negedge clk);
    regRead(A_EVENT, r);
    check("R8", "tnf high after load", r & 32'h100, 32'h100);
    check("R11", "tnf unmasked gives no irq", 32'(irqOut), 32'h0);
    repeat (WAIT_CYC) @(negedge clk);
    check("R11", "irq with rne and mask", 32'(irqOut), 32'h1);
    regWrite(A_EVENT, 32'h000);
    regRead(A_EVENT, r);
    check("R10", "writing zero keeps flags", r, 32'h300);
    regWrite(A_MASK, 32'h000);
    #1;
    check("R11", "mask off drops irq", 32'(irqOut), 32'h0);
    regWrite(A_MASK, 32'h100);
    #1;
    check("R11", "tnf masked raises irq", 32'(irqOut), 32'h1);
    regWrite(A_EVENT, 32'h100);
    regRead(A_EVENT, r);
    check("R10", "clear only tnf", r, 32'h200);
    check("R11", "irq after tnf clear", 32'(irqOut), 32'h0);
    regWrite(A_MASK, 32'h000);
  endtask

  task automatic testLoop();
    logic [31:0] r;
    regWrite(A_EVENT, 32'h300);
    regWrite(A_MODE, modeWord(1'b1, 1'b0, 1'b1, 1'b0, 4'd9, 1'b1));
    misoIn = 1'b1;
    regWrite(A_TX, 32'hFFFF_F2A4);
    repeat (WAIT_CYC) @(negedge clk);
    regRead(A_RX, r);
    check("R6", "loopback ignores misoIn", r, 32'h0000_02A4);
  endtask

  task automatic testDisabled();
    logic [31:0] r;
    regWrite(A_MODE, modeWord(1'b1, 1'b0, 1'b0, 1'b1, 4'd7, 1'b0));
    regWrite(A_EVENT, 32'h300);
    toggleCnt = 0;
    regWrite(A_TX, 32'h0000_005A);
    repeat (100) @(negedge clk);
    check("R7", "no clock while disabled", 32'(toggleCnt), 32'h0);
    regRead(A_EVENT, r);
    check("R7", "no load while disabled", r, 32'h0);
    regWrite(A_MODE, modeWord(1'b1, 1'b0, 1'b0, 1'b1, 4'd7, 1'b1));
    repeat (WAIT_CYC) @(negedge clk);
    regRead(A_RX, r);
    check("R7", "queued word sent on enable", r, 32'h0000_005A);
    regRead(A_EVENT, r);
    check("R7", "events after enable", r, 32'h300);
  endtask

  task automatic testOverwrite();
    logic [31:0] r;
    regWrite(A_MODE, modeWord(1'b1, 1'b1, 1'b0, 1'b1, 4'd7, 1'b1));
    regWrite(A_TX, 32'h0000_00A5);
    repeat (WAIT_CYC) @(negedge clk);
    regWrite(A_TX, 32'h0000_003C);
    repeat (WAIT_CYC) @(negedge clk);
    regRead(A_RX, r);
    check("R9", "second word overwrites", r, 32'h0000_003C);
    regRead(A_EVENT, r);
    check("R9", "rne still set", r & 32'h200, 32'h200);
  endtask

  initial begin
    #2_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    xfer("R2 R3 R4 R9", 1'b0, 1'b0, 1'b1, 4'd7, 8, 32'h0000_00B6, 32'h0000_0059);
    xfer("R2 R3 R4 R5", 1'b1, 1'b1, 1'b0, 4'd11, 12, 32'h0000_0C35, 32'h0000_0A93);
    xfer("R3 R5", 1'b0, 1'b1, 1'b1, 4'd0, 32, 32'hC0DE_5A17, 32'h8E21_F04B);
    xfer("R2 R4 R5", 1'b1, 1'b0, 1'b0, 4'd1, 4, 32'hFFFF_FFF9, 32'h0000_0006);
    xfer("R3 R5", 1'b1, 1'b0, 1'b1, 4'd15, 16, 32'h0001_9E3C, 32'h0000_4D71);
    testTnfAndIrq();
    testLoop();
    testDisabled();
    testOverwrite();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule